// File: doc/BRIEF.md
# Cached Virtual-to-Physical Address Translator

This block turns a 14-bit virtual address into a 12-bit physical address for a small paged memory with 64-byte pages. The low six address bits are the offset within a page and pass straight through; the upper eight bits form the virtual page number. That page number is first looked up in a 16-entry translation cache, organised as four sets of four ways. The cache set comes from the two low bits of the page number and the remaining six bits form the tag.

When the cache misses, the block spends one extra cycle reading a 256-entry page table indexed by the page number. A valid entry gives the physical page number and is written into the cache. An invalid entry reports a page fault instead. Software or a walker fills the page table through a write port. Every page-table write removes any cached copy of that page. A flush input empties the whole cache.

A request is a one-cycle pulse on `req_valid` while `busy` is low. The result appears as a one-cycle `done` pulse together with `tlb_hit`, `page_fault` and `paddr`.

Top module: `addr_xlate_top`

## Requirements
- R1: On every completed translation without a fault, `paddr[5:0]` equals `req_vaddr[5:0]` of that request, and `paddr[11:6]` is the physical page number.
- R2: The cache set is `vaddr[7:6]` (virtual page number bits 1:0) and the tag is `vaddr[13:8]`. Four pages sharing one set but with different tags are all held at once and all hit.
- R3: A request that hits in the cache gives `done=1`, `tlb_hit=1`, `page_fault=0` and the cached translation on the first clock edge after it is accepted.
- R4: A request that misses the cache and finds a valid page-table entry gives `done=1`, `tlb_hit=0`, `page_fault=0` and the table's translation on the second clock edge after acceptance. The translation is then cached, so a repeat of the same page hits.
- R5: A miss that finds an invalid page-table entry gives `done=1` and `page_fault=1` on the second edge, with `paddr=0` and `tlb_hit=0`. Nothing is cached, so a repeat faults again.
- R6: A refill takes the lowest-numbered invalid way of its set. When no way is invalid, it takes the way named by a per-set rotating pointer. After each refill the pointer moves to the way after the one just written.
- R7: A one-cycle `flush` pulse invalidates every cache entry, so later requests to any page miss.
- R8: A page-table write invalidates the cached entry for that page and leaves other cached pages intact. The next request to that page misses and returns the new mapping.
- R9: `busy` is high only in the cycle of the page-table read. A request presented while `busy` is high is ignored and produces no result.
- R10: If `flush`, or a page-table write to the same page, falls in the cycle in which a miss completes, that miss still reports the table value read before the write, but the refill is dropped. The next request to that page misses.
- R11: After reset, `done`, `tlb_hit`, `page_fault`, `busy` and `paddr` are zero, the cache is empty and every page-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request pulse, accepted when `busy` is low |
| req_vaddr | input | 14 | Virtual address of the request |
| flush | input | 1 | Invalidate every cache entry |
| pt_wr_en | input | 1 | Page-table write strobe |
| pt_wr_vpn | input | 8 | Page number of the entry written |
| pt_wr_ppn | input | 6 | Physical page number written |
| pt_wr_valid | input | 1 | Valid bit written |
| busy | output | 1 | Page-table read in progress; requests ignored |
| done | output | 1 | One-cycle pulse: result is present |
| tlb_hit | output | 1 | Result came from the cache |
| page_fault | output | 1 | Page-table entry was invalid |
| paddr | output | 12 | Physical address, zero on a fault |

## Verification
Two events can fall on the same clock edge: the completion of a page-table read with its cache refill, and a cache invalidation caused either by `flush` or by a page-table write to the page being refilled. The bench issues a missing request and drives the flush pulse or the conflicting table write in the very next cycle, while `busy` is high. It then checks that the result carries the table value read before the write, and that a repeat request to that page misses again with two-cycle latency and the new mapping.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 14;
    localparam int PA_W      = 12;
    localparam int OFF_W     = 6;
    localparam int TLB_SETS  = 4;
    localparam int TLB_WAYS  = 4;

    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int SET_W     = $clog2(TLB_SETS);
    localparam int TAG_W     = VPN_W - SET_W;
    localparam int WAY_W     = $clog2(TLB_WAYS);
    localparam int PT_DEPTH  = 1 << VPN_W;

    typedef logic [VA_W-1:0]  vaddr_t;
    typedef logic [PA_W-1:0]  paddr_t;
    typedef logic [OFF_W-1:0] off_t;
    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [SET_W-1:0] set_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        ppn_t ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic valid;
        ppn_t ppn;
    } pte_t;

    typedef struct packed {
        logic   hit;
        logic   fault;
        paddr_t paddr;
    } xlat_result_t;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } xlat_state_e;

    function automatic vpn_t vpn_of(vaddr_t va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(vaddr_t va);
        return va[OFF_W-1:0];
    endfunction

    function automatic set_t set_of(vpn_t vpn);
        return vpn[SET_W-1:0];
    endfunction

    function automatic tag_t tag_of(vpn_t vpn);
        return vpn[VPN_W-1:SET_W];
    endfunction

    function automatic paddr_t make_pa(ppn_t ppn, off_t off);
        return {ppn, off};
    endfunction

endpackage

// File: rtl/xlat_page_table.sv
module xlat_page_table
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  vpn_t wr_vpn,
    input  pte_t wr_pte,
    input  vpn_t rd_vpn,
    output pte_t rd_pte
);

    pte_t table_q [PT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PT_DEPTH; i++) begin
                table_q[i] <= '0;
            end
        end else if (wr_en) begin
            table_q[wr_vpn] <= wr_pte;
        end
    end

    // Asynchronous read: a write in the same cycle is seen only afterwards.
    assign rd_pte = table_q[rd_vpn];

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  vpn_t lk_vpn,
    output logic lk_hit,
    output ppn_t lk_ppn,
    input  logic fill_en,
    input  vpn_t fill_vpn,
    input  ppn_t fill_ppn,
    input  logic flush,
    input  logic inv_en,
    input  vpn_t inv_vpn
);

    tlb_entry_t ent_q [TLB_SETS][TLB_WAYS];
    way_t       rr_q  [TLB_SETS];

    set_t                lk_set;
    tag_t                lk_tag;
    logic [TLB_WAYS-1:0] way_hit;

    assign lk_set = set_of(lk_vpn);
    assign lk_tag = tag_of(lk_vpn);

    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way_cmp
        assign way_hit[w] = ent_q[lk_set][w].valid && (ent_q[lk_set][w].tag == lk_tag);
    end

    assign lk_hit = |way_hit;

    always_comb begin
        lk_ppn = '0;
        for (int w = 0; w < TLB_WAYS; w++) begin
            if (way_hit[w]) begin
                lk_ppn = lk_ppn | ent_q[lk_set][w].ppn;
            end
        end
    end

    // Victim choice: lowest invalid way, else rotating pointer of the set.
    set_t fill_set;
    way_t victim;
    logic free_found;

    assign fill_set = set_of(fill_vpn);

    always_comb begin
        victim     = rr_q[fill_set];
        free_found = 1'b0;
        for (int w = 0; w < TLB_WAYS; w++) begin
            if (!free_found && !ent_q[fill_set][w].valid) begin
                victim     = way_t'(w);
                free_found = 1'b1;
            end
        end
    end

    // Invalidation of the same page (or a flush) beats the refill.
    logic fill_ok;
    assign fill_ok = fill_en && !flush && !(inv_en && (inv_vpn == fill_vpn));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < TLB_SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < TLB_WAYS; w++) begin
                    ent_q[s][w] <= '0;
                end
            end
        end else begin
            for (int s = 0; s < TLB_SETS; s++) begin
                for (int w = 0; w < TLB_WAYS; w++) begin
                    if (flush) begin
                        ent_q[s][w].valid <= 1'b0;
                    end else if (inv_en && (set_t'(s) == set_of(inv_vpn))
                                 && (ent_q[s][w].tag == tag_of(inv_vpn))) begin
                        ent_q[s][w].valid <= 1'b0;
                    end
                end
            end
            if (fill_ok) begin
                ent_q[fill_set][victim] <= '{valid: 1'b1, tag: tag_of(fill_vpn), ppn: fill_ppn};
                rr_q[fill_set]          <= victim + way_t'(1);
            end
        end
    end

endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
    import xlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            flush,
    input  logic            pt_wr_en,
    input  logic [VPN_W-1:0] pt_wr_vpn,
    input  logic [PPN_W-1:0] pt_wr_ppn,
    input  logic            pt_wr_valid,
    output logic            busy,
    output logic            done,
    output logic            tlb_hit,
    output logic            page_fault,
    output logic [PA_W-1:0] paddr
);

    xlat_state_e  state_q;
    vaddr_t       pend_q;
    xlat_result_t res_q;
    logic         done_q;

    logic accept;
    logic lk_hit;
    ppn_t lk_ppn;
    pte_t rd_pte;
    logic fill_en;

    assign busy   = (state_q == ST_WALK);
    assign accept = req_valid && (state_q == ST_IDLE);

    xlat_tlb u_tlb (
        .clk      (clk),
        .rst      (rst),
        .lk_vpn   (vpn_of(req_vaddr)),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn),
        .fill_en  (fill_en),
        .fill_vpn (vpn_of(pend_q)),
        .fill_ppn (rd_pte.ppn),
        .flush    (flush),
        .inv_en   (pt_wr_en),
        .inv_vpn  (pt_wr_vpn)
    );

    xlat_page_table u_pt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (pt_wr_en),
        .wr_vpn (pt_wr_vpn),
        .wr_pte ('{valid: pt_wr_valid, ppn: pt_wr_ppn}),
        .rd_vpn (vpn_of(pend_q)),
        .rd_pte (rd_pte)
    );

    assign fill_en = (state_q == ST_WALK) && rd_pte.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            res_q  <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            done_q <= 1'b1;
                            res_q  <= '{hit: 1'b1, fault: 1'b0,
                                        paddr: make_pa(lk_ppn, off_of(req_vaddr))};
                        end else begin
                            pend_q  <= req_vaddr;
                            state_q <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                    if (rd_pte.valid) begin
                        res_q <= '{hit: 1'b0, fault: 1'b0,
                                   paddr: make_pa(rd_pte.ppn, off_of(pend_q))};
                    end else begin
                        res_q <= '{hit: 1'b0, fault: 1'b1, paddr: '0};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done       = done_q;
    assign tlb_hit    = res_q.hit;
    assign page_fault = res_q.fault;
    assign paddr      = res_q.paddr;

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
    import xlat_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            busy,
    input logic            done,
    input logic            tlb_hit,
    input logic            page_fault,
    input logic [PA_W-1:0] paddr
);

    off_t last_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_off <= '0;
        end else if (req_valid && !busy) begin
            last_off <= req_vaddr[OFF_W-1:0];
        end
    end

    // R1: offset of the accepted request reaches the output unchanged
    p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (done && !page_fault) |-> (paddr[OFF_W-1:0] == last_off));

    // R3: a hit result follows an accepted request by one edge
    p_hit_latency_r3: assert property (@(posedge clk) disable iff (rst)
        tlb_hit |-> (done && $past(req_valid && !busy)));

    // R4: leaving the table-read cycle always delivers a non-hit result
    p_walk_result_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && !tlb_hit));

    // R5: a fault carries a zero address and no hit
    p_fault_clean_r5: assert property (@(posedge clk) disable iff (rst)
        page_fault |-> (done && !tlb_hit && (paddr == '0)));

    // R9: the table read lasts exactly one cycle
    p_busy_single_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9: every result has an accepted request or table read behind it
    p_done_source_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) || $past(req_valid && !busy)));

endmodule

bind addr_xlate_top xlat_checker u_xlat_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .busy       (busy),
    .done       (done),
    .tlb_hit    (tlb_hit),
    .page_fault (page_fault),
    .paddr      (paddr)
);

// File: tb/addr_xlate_top_tb_top.sv
module addr_xlate_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        flush = 1'b0;
    logic        pt_wr_en = 1'b0;
    logic [7:0]  pt_wr_vpn = '0;
    logic [5:0]  pt_wr_ppn = '0;
    logic        pt_wr_valid = 1'b0;
    logic        busy, done, tlb_hit, page_fault;
    logic [11:0] paddr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct {
        logic        hit;
        logic        fault;
        logic [11:0] pa;
        int          lat;
        int          issued;
        string       req;
    } exp_t;

    exp_t sb_q [$];
    exp_t cur;

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc++;

    addr_xlate_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .flush       (flush),
        .pt_wr_en    (pt_wr_en),
        .pt_wr_vpn   (pt_wr_vpn),
        .pt_wr_ppn   (pt_wr_ppn),
        .pt_wr_valid (pt_wr_valid),
        .busy        (busy),
        .done        (done),
        .tlb_hit     (tlb_hit),
        .page_fault  (page_fault),
        .paddr       (paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every result.
    always @(negedge clk) begin
        if (!rst && done) begin
            n_tests++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected result hit=%0b fault=%0b pa=%h, expected none",
                         tlb_hit, page_fault, paddr);
            end else begin
                cur = sb_q.pop_front();
                if (tlb_hit !== cur.hit || page_fault !== cur.fault ||
                    paddr !== cur.pa || (cyc - cur.issued) != cur.lat) begin
                    n_fail++;
                    $display("FAIL %s: hit=%0b fault=%0b pa=%h lat=%0d, expected hit=%0b fault=%0b pa=%h lat=%0d",
                             cur.req, tlb_hit, page_fault, paddr, cyc - cur.issued,
                             cur.hit, cur.fault, cur.pa, cur.lat);
                end
            end
        end
    end

    task automatic push_exp(input logic h, input logic f, input logic [11:0] pa, input string req);
        exp_t e;
        e.hit = h; e.fault = f; e.pa = pa;
        e.lat = h ? 1 : 2;
        e.issued = cyc;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_empty();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [13:0] va, input logic h, input logic f,
                         input logic [11:0] pa, input string req);
        req_valid = 1'b1;
        req_vaddr = va;
        push_exp(h, f, pa, req);
        @(negedge clk);
        req_valid = 1'b0;
        wait_empty();
    endtask

    task automatic pt_write(input logic [7:0] vpn, input logic [5:0] ppn, input logic v);
        pt_wr_en = 1'b1; pt_wr_vpn = vpn; pt_wr_ppn = ppn; pt_wr_valid = v;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    // Miss whose completion cycle coincides with a flush or a table write.
    task automatic issue_coincide(input logic [13:0] va, input logic [11:0] pa,
                                  input logic use_flush, input logic [5:0] new_ppn);
        req_valid = 1'b1;
        req_vaddr = va;
        push_exp(1'b0, 1'b0, pa, "R10");
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy", {31'd0, busy}, 32'd1);
        if (use_flush) begin
            flush = 1'b1;
        end else begin
            pt_wr_en = 1'b1; pt_wr_vpn = va[13:6]; pt_wr_ppn = new_ppn; pt_wr_valid = 1'b1;
        end
        @(negedge clk);
        flush = 1'b0;
        pt_wr_en = 1'b0;
        wait_empty();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9: watchdog expired, run hung");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: quiet outputs after reset, empty table
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 hit", {31'd0, tlb_hit}, 32'd0);
        chk("R11 paddr", {20'd0, paddr}, 32'd0);
        issue(14'h03D4, 1'b0, 1'b1, 12'h000, "R11");

        pt_write(8'h0F, 6'h0D, 1'b1);
        pt_write(8'h00, 6'h28, 1'b1);

        // R4 miss then R3 hit, R1 offset pass-through
        issue(14'h03D4, 1'b0, 1'b0, 12'h354, "R4");
        issue(14'h03D4, 1'b1, 1'b0, 12'h354, "R3");
        issue(14'h03FF, 1'b1, 1'b0, 12'h37F, "R1");
        issue(14'h0020, 1'b0, 1'b0, 12'hA20, "R4");
        issue(14'h0020, 1'b1, 1'b0, 12'hA20, "R3");

        // R5: invalid entry faults and is not cached
        issue(14'h0150, 1'b0, 1'b1, 12'h000, "R5");
        issue(14'h0150, 1'b0, 1'b1, 12'h000, "R5");

        // R2 / R6: five pages in set 1
        pt_write(8'h01, 6'h11, 1'b1);
        pt_write(8'h09, 6'h19, 1'b1);
        pt_write(8'h0D, 6'h1D, 1'b1);
        pt_write(8'h11, 6'h21, 1'b1);
        pt_write(8'h15, 6'h25, 1'b1);
        issue(14'h0040, 1'b0, 1'b0, 12'h440, "R2");
        issue(14'h0240, 1'b0, 1'b0, 12'h640, "R2");
        issue(14'h0340, 1'b0, 1'b0, 12'h740, "R2");
        issue(14'h0440, 1'b0, 1'b0, 12'h840, "R2");
        issue(14'h0040, 1'b1, 1'b0, 12'h440, "R2");
        issue(14'h0240, 1'b1, 1'b0, 12'h640, "R2");
        issue(14'h0340, 1'b1, 1'b0, 12'h740, "R2");
        issue(14'h0440, 1'b1, 1'b0, 12'h840, "R2");
        issue(14'h0540, 1'b0, 1'b0, 12'h940, "R6");   // evicts way 0 (page 0x01)
        issue(14'h0240, 1'b1, 1'b0, 12'h640, "R6");
        issue(14'h0540, 1'b1, 1'b0, 12'h940, "R6");
        issue(14'h0040, 1'b0, 1'b0, 12'h440, "R6");   // evicts way 1 (page 0x09)
        issue(14'h0240, 1'b0, 1'b0, 12'h640, "R6");   // evicts way 2 (page 0x0D)
        issue(14'h0440, 1'b1, 1'b0, 12'h840, "R6");
        issue(14'h0340, 1'b0, 1'b0, 12'h740, "R6");   // evicts way 3 (page 0x11)
        issue(14'h0540, 1'b1, 1'b0, 12'h940, "R6");

        // R8: table write drops only the matching cached page
        pt_write(8'h0F, 6'h2A, 1'b1);
        issue(14'h0020, 1'b1, 1'b0, 12'hA20, "R8");
        issue(14'h03D4, 1'b0, 1'b0, 12'hA94, "R8");
        issue(14'h03D4, 1'b1, 1'b0, 12'hA94, "R8");

        // R7: flush empties the cache
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        issue(14'h0020, 1'b0, 1'b0, 12'hA20, "R7");
        issue(14'h03D4, 1'b0, 1'b0, 12'hA94, "R7");

        // R9: request during busy is ignored
        req_valid = 1'b1;
        req_vaddr = 14'h0440;
        push_exp(1'b0, 1'b0, 12'h840, "R9");
        @(negedge clk);
        chk("R9 busy", {31'd0, busy}, 32'd1);
        req_vaddr = 14'h0240;
        @(negedge clk);
        req_valid = 1'b0;
        wait_empty();
        repeat (3) @(negedge clk);
        issue(14'h0240, 1'b0, 1'b0, 12'h640, "R9");

        // R10: invalidation coinciding with miss completion
        pt_write(8'h30, 6'h07, 1'b1);
        issue_coincide(14'h0C00, 12'h1C0, 1'b1, 6'h00);
        issue(14'h0C00, 1'b0, 1'b0, 12'h1C0, "R10");
        pt_write(8'h31, 6'h08, 1'b1);
        issue_coincide(14'h0C40, 12'h200, 1'b0, 6'h09);
        issue(14'h0C40, 1'b0, 1'b0, 12'h240, "R10");
        issue(14'h0C40, 1'b1, 1'b0, 12'h240, "R10");

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule